// File: doc/BRIEF.md
# Widening Lane Shift-Left Unit

This unit takes one 64-bit half of a 128-bit vector operand and splits it into equal lanes of 8, 16 or 32 bits. Each lane is extended to twice its width, either sign-extended or zero-extended. It is then shifted left by an immediate amount. The widened lanes are packed side by side into a full 128-bit result. The lane width and the shift amount both come from a 7-bit immediate, formed by a 4-bit high field and a 3-bit low field. A select input picks the lower or upper half of the source. An extension-mode input picks between sign and zero extension.

The operation is captured in one register stage when `issue` is high. The unit reads the whole selected half in that same clock edge. It writes no part of the result before the source has been sampled. For this reason the result may be routed back to the same vector register that supplied the source. Encodings that name no legal lane width raise `unalloc` and produce an all-zero result.

Top module: `wsl_widen_shift`

## Requirements
- R1: While reset is asserted, and until the first issued operation, `result` is zero and `unalloc` is 0.
- R2: `upper_half`=0 takes the source lanes from `src[63:0]`. `upper_half`=1 takes them from `src[127:64]`.
- R3: `unsigned_ext`=0 sign-extends each lane to double width before the shift. `unsigned_ext`=1 zero-extends it.
- R4: The highest set bit of `immh` gives the lane width w: `immh`=4'b0001 gives 8, 4'b001x gives 16, and 4'b01xx gives 32. The shift amount is the 7-bit value {`immh`,`immb`} minus w.
- R5: If `immh[3]`=1, or if `immh`=0, the encoding is unallocated. `unalloc` then reads 1 and `result` reads zero.
- R6: A shift amount of zero yields the plain double-width extension of each lane.
- R7: Output lane i occupies `result` bits [(i+1)*2w-1 : i*2w]. Its source is input lane i of the selected half, at bits [(i+1)*w-1 : i*w].
- R8: When `issue` is low, `result` and `unalloc` hold their values, whatever the other inputs do.
- R9: An operation issued at a clock edge appears on `result` and `unalloc` right after that edge. All lanes are computed from the source value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the unit |
| issue | input | 1 | Capture enable: performs the operation at this edge |
| immh | input | 4 | High immediate field: lane width and upper shift bits |
| immb | input | 3 | Low immediate field: lower shift bits |
| unsigned_ext | input | 1 | 1 = zero-extend lanes, 0 = sign-extend lanes |
| upper_half | input | 1 | 1 = source lanes from bits 127:64, 0 = from bits 63:0 |
| src | input | 128 | Source vector |
| result | output | 128 | Widened and shifted result |
| unalloc | output | 1 | The last issued encoding was unallocated |

## Verification
A wrong lane-width decode moves every lane boundary, so the whole vector is wrong in the cycle right after the issuing edge. An off-by-one shift amount shows up as zero bits at the wrong positions in that same cycle. A faulty extension only appears when a lane's top bit is set. The random source patterns therefore give each lane's sign bit an even chance, and directed all-ones operands force that case. A broken hold path shows up one cycle after any idle edge whose inputs differ from those of the last operation.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  // Lane-width selector; the enum value k means a lane width of 8<<k bits
  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2,
    LWNA = 2'd3
  } lane_sel_t;

  localparam int NUM_WIDTHS = 3;
  localparam int MIN_LANE_W = 8;
  localparam int SHAMT_W    = 5;
endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
  import wsl_pkg::*;
(
  input  logic [3:0]         immh,
  input  logic [2:0]         immb,
  output lane_sel_t          sel,
  output logic [SHAMT_W-1:0] shamt,
  output logic               bad
);
  logic [6:0] code;
  logic [6:0] diff;

  always_comb begin
    code  = {immh, immb};
    sel   = LWNA;
    bad   = 1'b1;
    diff  = 7'd0;
    casez (immh)
      4'b01??: begin sel = LW32; bad = 1'b0; diff = code - 7'd32; end
      4'b001?: begin sel = LW16; bad = 1'b0; diff = code - 7'd16; end
      4'b0001: begin sel = LW8;  bad = 1'b0; diff = code - 7'd8;  end
      default: begin sel = LWNA; bad = 1'b1; diff = 7'd0;         end
    endcase
    shamt = diff[SHAMT_W-1:0];
  end
endmodule

// File: rtl/wsl_widen.sv
module wsl_widen
  import wsl_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [HALF_W-1:0]   half,
  input  logic                sgn,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [2*HALF_W-1:0] wide
);
  localparam int NLANES = HALF_W / LANE_W;
  localparam int OUT_W  = 2 * LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane;
    logic [OUT_W-1:0]  ext;
    assign lane = half[i*LANE_W +: LANE_W];
    assign ext  = {{LANE_W{sgn & lane[LANE_W-1]}}, lane};
    assign wide[i*OUT_W +: OUT_W] = ext << shamt;
  end
endmodule

// File: rtl/wsl_rst_sync.sv
module wsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wsl_widen_shift.sv
module wsl_widen_shift
  import wsl_pkg::*;
#(
  parameter int SRC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [3:0]       immh,
  input  logic [2:0]       immb,
  input  logic             unsigned_ext,
  input  logic             upper_half,
  input  logic [SRC_W-1:0] src,
  output logic [SRC_W-1:0] result,
  output logic             unalloc
);
  localparam int HALF_W = SRC_W / 2;

  logic               rst_sync_n;
  lane_sel_t          sel;
  logic [SHAMT_W-1:0] shamt;
  logic               bad;
  logic [HALF_W-1:0]  half;
  logic [SRC_W-1:0]   wide [NUM_WIDTHS];
  logic [SRC_W-1:0]   picked;
  logic [SRC_W-1:0]   result_d, result_q;
  logic               unalloc_d, unalloc_q;

  wsl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsl_decode u_dec (
    .immh  (immh),
    .immb  (immb),
    .sel   (sel),
    .shamt (shamt),
    .bad   (bad)
  );

  assign half = upper_half ? src[SRC_W-1:HALF_W] : src[HALF_W-1:0];

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    wsl_widen #(
      .HALF_W (HALF_W),
      .LANE_W (MIN_LANE_W << k)
    ) u_widen (
      .half  (half),
      .sgn   (~unsigned_ext),
      .shamt (shamt),
      .wide  (wide[k])
    );
  end

  always_comb begin
    case (sel)
      LW8:     picked = wide[0];
      LW16:    picked = wide[1];
      LW32:    picked = wide[2];
      default: picked = '0;
    endcase
  end

  // next state, clock enable written out
  always_comb begin
    result_d  = result_q;
    unalloc_d = unalloc_q;
    if (issue) begin
      result_d  = bad ? '0 : picked;
      unalloc_d = bad;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q  <= '0;
      unalloc_q <= 1'b0;
    end else begin
      result_q  <= result_d;
      unalloc_q <= unalloc_d;
    end
  end

  assign result  = result_q;
  assign unalloc = unalloc_q;
endmodule

// File: rtl/wsl_checker.sv
module wsl_checker #(
  parameter int SRC_W = 128
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             issue,
  input logic [3:0]       immh,
  input logic [2:0]       immb,
  input logic             unsigned_ext,
  input logic             upper_half,
  input logic [SRC_W-1:0] src,
  input logic [SRC_W-1:0] result,
  input logic             unalloc
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue |=> ($stable(result) && $stable(unalloc)));

  p_unalloc_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && (immh[3] || immh == 4'd0)) |=> (unalloc && result == '0));

  p_legal_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && !immh[3] && immh != 4'd0) |=> !unalloc);

  // byte lanes, no shift, zero extension, lower half: lane 0 is the plain byte
  p_zero_shift_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && immh == 4'b0001 && immb == 3'd0 && unsigned_ext && !upper_half)
    |=> (result[15:0] == {8'd0, $past(src[7:0])}));

  // word lanes with a sign-extended top bit: upper bits of lane 0 all ones, no shift
  p_sign_ext_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && immh == 4'b0100 && immb == 3'd0 && !unsigned_ext && !upper_half && src[31])
    |=> (result[63:32] == 32'hFFFF_FFFF));
endmodule

bind wsl_widen_shift wsl_checker #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/sim_wsl_widen_shift.sv
module sim_wsl_widen_shift;
  logic         clk;
  logic         rst_n;
  logic         issue;
  logic [3:0]   immh;
  logic [2:0]   immb;
  logic         unsigned_ext;
  logic         upper_half;
  logic [127:0] src;
  logic [127:0] result;
  logic         unalloc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  wsl_widen_shift u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .immh         (immh),
    .immb         (immb),
    .unsigned_ext (unsigned_ext),
    .upper_half   (upper_half),
    .src          (src),
    .result       (result),
    .unalloc      (unalloc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected {unalloc, result}, computed from the requirements
  function automatic logic [128:0] model(input logic [3:0] h, input logic [2:0] b,
                                         input logic u, input logic q,
                                         input logic [127:0] s);
    int w;
    int sh;
    logic [63:0]  hv;
    logic [127:0] r;
    logic [63:0]  lmask;
    logic [63:0]  omask;
    if (h[3] || h == 4'd0) return {1'b1, 128'd0};
    w  = h[2] ? 32 : (h[1] ? 16 : 8);
    sh = int'({h, b}) - w;
    hv = q ? s[127:64] : s[63:0];
    r  = '0;
    lmask = (64'd1 << w) - 64'd1;
    omask = (w == 32) ? {64{1'b1}} : ((64'd1 << (2 * w)) - 64'd1);
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] v;
      v = (hv >> (i * w)) & lmask;
      if (!u && v[w-1]) v = v | ~lmask;
      v = (v << sh) & omask;
      r = r | (128'(v) << (i * 2 * w));
    end
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [127:0] act_r, input logic act_u,
                       input logic [127:0] exp_r, input logic exp_u);
    n_checks++;
    if (act_r !== exp_r || act_u !== exp_u) begin
      n_fail++;
      $display("FAIL %s: got unalloc=%0b result=%h, expected unalloc=%0b result=%h",
               req, act_u, act_r, exp_u, exp_r);
    end
  endtask

  // called at a negedge; checks at the following negedge
  task automatic run_op(input string req, input logic [3:0] h, input logic [2:0] b,
                        input logic u, input logic q, input logic [127:0] s);
    logic [128:0] e;
    immh = h; immb = b; unsigned_ext = u; upper_half = q; src = s;
    issue = 1'b1;
    e = model(h, b, u, q, s);
    @(negedge clk);
    issue = 1'b0;
    check(req, result, unalloc, e[127:0], e[128]);
  endtask

  initial begin
    logic [127:0] keep_r;
    logic         keep_u;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; issue = 1'b0; immh = '0; immb = '0;
    unsigned_ext = 1'b0; upper_half = 1'b0; src = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", result, unalloc, 128'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", result, unalloc, 128'd0, 1'b0);

    // R6: pure extension, zero shift, each lane width
    run_op("R6", 4'b0001, 3'd0, 1'b1, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    run_op("R6", 4'b0010, 3'd0, 1'b0, 1'b0, 128'h0123_4567_89AB_CDEF_8000_7FFF_FFFF_0001);
    run_op("R6", 4'b0100, 3'd0, 1'b0, 1'b1, 128'h8000_0001_7FFF_FFFF_0000_0000_0000_0000);
    // R3: all-ones lanes, signed versus unsigned
    run_op("R3", 4'b0001, 3'd3, 1'b0, 1'b0, {128{1'b1}});
    run_op("R3", 4'b0001, 3'd3, 1'b1, 1'b0, {128{1'b1}});
    // R2: half selection with distinct halves
    run_op("R2", 4'b0011, 3'd5, 1'b1, 1'b1, 128'hAAAA_5555_1234_F00F_0000_0000_0000_0000);
    run_op("R2", 4'b0011, 3'd5, 1'b1, 1'b0, 128'hAAAA_5555_1234_F00F_0000_0000_0000_0001);
    // R4: maximum shifts for each width
    run_op("R4", 4'b0001, 3'd7, 1'b0, 1'b0, {128{1'b1}});
    run_op("R4", 4'b0011, 3'd7, 1'b0, 1'b1, 128'h8001_8001_8001_8001_0000_0000_0000_0000);
    run_op("R4", 4'b0111, 3'd7, 1'b1, 1'b0, 128'h0000_0000_0000_0000_FFFF_FFFF_0000_0001);
    // R7: one marked lane per position
    run_op("R7", 4'b0001, 3'd1, 1'b1, 1'b0, 128'h0000_0000_0000_0000_0000_0000_8100_0000);
    // R5: unallocated encodings
    run_op("R5", 4'b1000, 3'd2, 1'b1, 1'b0, {128{1'b1}});
    run_op("R5", 4'b1111, 3'd7, 1'b0, 1'b1, {128{1'b1}});
    run_op("R5", 4'b0000, 3'd4, 1'b0, 1'b0, {128{1'b1}});
    run_op("R9", 4'b0010, 3'd1, 1'b0, 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888);

    // R8: inputs change while issue is low
    keep_r = result; keep_u = unalloc;
    immh = 4'b1000; immb = 3'd1; src = ~src; upper_half = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", result, unalloc, keep_r, keep_u);

    // R9/R4/R7: constrained random operations
    for (int n = 0; n < 400; n++) begin
      logic [3:0] h;
      h = 4'($urandom_range(1, 7));
      if ($urandom_range(0, 15) == 0) h = 4'($urandom_range(0, 15));
      run_op("R9", h, 3'($urandom), 1'($urandom), 1'($urandom),
             {$urandom, $urandom, $urandom, $urandom});
      if ($urandom_range(0, 7) == 0) begin
        keep_r = result; keep_u = unalloc;
        src = {$urandom, $urandom, $urandom, $urandom};
        immh = 4'($urandom);
        @(negedge clk);
        check("R8", result, unalloc, keep_r, keep_u);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule